// File: doc/BRIEF.md
# Fixed-Latency Radix-2 Montgomery Multiplier

This block multiplies two residues in the Montgomery domain for an odd modulus `N` of `MOD_W` bits. It takes operands `X` and `Y`, each below `2N`, and returns `T` with `T ≡ X·Y·2^-(MOD_W+2) (mod N)` and `T < 2N`. The radix `R = 2^(MOD_W+2)` is more than four times any legal modulus. Because of this, every intermediate value stays bounded and the block never applies a closing conditional subtraction. A result below `2N` can be fed straight back as an operand, for example in an exponentiation or a point-arithmetic chain. A final reduction below `N` is left to the caller.

A one-cycle `start` captures `X`, `Y` and `N` into internal registers. The block then runs `MOD_W+2` bit-serial iterations on a sum row and a carry row, both in carry-save form, with one iteration per clock. A quotient bit picked each iteration makes the running sum even, so it can be halved exactly. After the iterations, a one-bit serial adder merges the two rows into plain binary. The result appears with a one-cycle `done` strobe. The total latency is the same for every operand set.

Top module: `mont_nfs_mul`

## Requirements
- R1: After `MOD_W+2` iterations `t_out` equals the result of the recurrence T ← (T + x_i·Y + m_i·N)/2 for i = 0 … MOD_W+1. This starts from T = 0, x_i is bit i of X (bit 0 first) and m_i = (T + x_i·Y) mod 2. As a result, t_out·2^(MOD_W+2) ≡ X·Y (mod N).
- R2: For odd N and X, Y < 2N, the value on `t_out` while `done` is high is below 2N. No subtraction is applied to it.
- R3: `done` rises exactly 3·MOD_W+4 clock edges after the edge that samples an accepted `start`, for every operand value.
- R4: In every iteration the quotient bit makes the four-term sum even, so the halving discards no set bit.
- R5: X, Y and N are captured at the accepted `start`. Changing the input pins after that edge does not alter the result.
- R6: `done` is high for exactly one cycle per operation. `t_out` changes only in the cycle in which `done` is raised, and holds its value until the next operation completes.
- R7: A `start` seen while an operation is in progress is ignored. This includes the cycle in which `done` is high. It neither restarts the count nor changes the result, and it produces no extra `done`.
- R8: While reset is asserted and after it is released, `done` is 0 and `t_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the block is idle |
| x_in | input | MOD_W+1 | Operand X, below 2N |
| y_in | input | MOD_W+1 | Operand Y, below 2N |
| n_in | input | MOD_W | Odd modulus N |
| done | output | 1 | One-cycle strobe, result valid |
| t_out | output | MOD_W+1 | Montgomery product, below 2N |

## Verification
With MOD_W = 4, the result is due 16 edges after the edge that samples `start`. The bench drives inputs on falling edges and counts falling edges until `done` is seen, so each check samples half a cycle after the register that drives it. When `done` appears, the bench checks `t_out` against the integer recurrence and against the modular congruence, and checks the count. The following falling edges check that `done` has dropped and that `t_out` holds. Stray `start` pulses are placed mid-operation and in the `done` cycle, and the bench then watches a full latency window for an unexpected strobe or a change in value.

// File: rtl/mont_nfs_pkg.sv
package mont_nfs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MUL1 = 2'd1,
      ST_MUL2 = 2'd2,
      ST_OUT  = 2'd3
   } mnfs_state_e;

   function automatic int unsigned mnfs_latency(input int unsigned w);
      return 3 * w + 4;
   endfunction
endpackage

// File: rtl/mnfs_csa.sv
module mnfs_csa #(
   parameter int unsigned WD = 8
) (
   input  logic [WD-1:0] a_i,
   input  logic [WD-1:0] b_i,
   input  logic [WD-1:0] c_i,
   output logic [WD-1:0] sum_o,
   output logic [WD-1:0] cry_o
);
   assign cry_o[0] = 1'b0;
   for (genvar j = 0; j < WD; j++) begin : g_bit
      assign sum_o[j] = a_i[j] ^ b_i[j] ^ c_i[j];
      if (j < WD - 1) begin : g_cry
         assign cry_o[j+1] = (a_i[j] & b_i[j]) | (a_i[j] & c_i[j]) | (b_i[j] & c_i[j]);
      end
   end
endmodule

// File: rtl/mnfs_iter.sv
module mnfs_iter #(
   parameter int unsigned MOD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             iter_en,
   input  logic             res_en,
   input  logic [MOD_W:0]   x_in,
   input  logic [MOD_W:0]   y_in,
   input  logic [MOD_W-1:0] n_in,
   output logic             s_bit,
   output logic             c_bit,
   output logic [MOD_W-1:0] n_held
);
   localparam int unsigned RW = MOD_W + 3;   // row width, holds any partial sum
   localparam int unsigned IW = RW + 1;      // one extra bit for the shifted carry
   localparam int unsigned XW = MOD_W + 2;   // one bit per iteration

   logic [XW-1:0]    x_sh;
   logic [MOD_W:0]   y_q;
   logic [MOD_W-1:0] n_q;
   logic [RW-1:0]    s_row, c_row;

   logic          x_cur, q_bit;
   logic [IW-1:0] op_s, op_c, op_y, op_n;
   logic [IW-1:0] s1, k1, s2, k2;

   always_comb begin
      x_cur = x_sh[0];
      q_bit = s_row[0] ^ c_row[0] ^ (x_cur & y_q[0]);
      op_s  = {1'b0, s_row};
      op_c  = {1'b0, c_row};
      op_y  = x_cur ? {{(IW-MOD_W-1){1'b0}}, y_q} : '0;
      op_n  = q_bit ? {{(IW-MOD_W){1'b0}}, n_q} : '0;
   end

   mnfs_csa #(.WD(IW)) u_csa_lo (
      .a_i(op_s), .b_i(op_c), .c_i(op_y), .sum_o(s1), .cry_o(k1)
   );
   mnfs_csa #(.WD(IW)) u_csa_hi (
      .a_i(s1), .b_i(k1), .c_i(op_n), .sum_o(s2), .cry_o(k2)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_sh  <= '0;
         y_q   <= '0;
         n_q   <= '0;
         s_row <= '0;
         c_row <= '0;
      end else if (load) begin
         x_sh  <= {1'b0, x_in};
         y_q   <= y_in;
         n_q   <= n_in;
         s_row <= '0;
         c_row <= '0;
      end else if (iter_en) begin
         x_sh  <= x_sh >> 1;
         s_row <= s2[RW:1];
         c_row <= k2[RW:1];
      end else if (res_en) begin
         s_row <= s_row >> 1;
         c_row <= c_row >> 1;
      end
   end

   assign s_bit  = s_row[0];
   assign c_bit  = c_row[0];
   assign n_held = n_q;

   // R4: the quotient leaves an even sum, so the halving drops nothing
   assert_even_before_halving_R4: assert property (@(posedge clk) disable iff (!rst_n)
      iter_en |-> (s2[0] == 1'b0 && k2[0] == 1'b0));
endmodule

// File: rtl/mnfs_resolve.sv
module mnfs_resolve #(
   parameter int unsigned RW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic          s_bit,
   input  logic          c_bit,
   output logic [RW-1:0] sum_o
);
   logic          cy;
   logic [RW-1:0] acc;
   logic          bit_now, cy_now;

   always_comb begin
      bit_now = s_bit ^ c_bit ^ cy;
      cy_now  = (s_bit & c_bit) | (s_bit & cy) | (c_bit & cy);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cy  <= 1'b0;
         acc <= '0;
      end else if (clr) begin
         cy  <= 1'b0;
         acc <= '0;
      end else if (step) begin
         cy  <= cy_now;
         acc <= {bit_now, acc[RW-1:1]};
      end
   end

   assign sum_o = acc;
endmodule

// File: rtl/mnfs_ctrl.sv
module mnfs_ctrl
   import mont_nfs_pkg::*;
#(
   parameter int unsigned MOD_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic iter_en,
   output logic res_en,
   output logic cap,
   output logic done
);
   localparam int unsigned LAT  = mnfs_latency(MOD_W);
   localparam int unsigned RW   = MOD_W + 3;
   localparam int unsigned CW   = $clog2(LAT + 2);
   localparam logic [CW-1:0] C_LAST_IT = CW'(MOD_W + 1);
   localparam logic [CW-1:0] C_RES_END = CW'(MOD_W + 2 + RW);
   localparam logic [CW-1:0] C_FINAL   = CW'(LAT - 1);

   mnfs_state_e   state;
   logic [CW-1:0] cnt;
   logic          done_q;

   always_comb begin
      load    = (state == ST_IDLE) && start;
      iter_en = (state == ST_MUL1);
      res_en  = (state == ST_MUL2) && (cnt < C_RES_END);
      cap     = (state == ST_MUL2) && (cnt == C_FINAL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= cap;
         unique case (state)
            ST_IDLE: if (start) begin
               state <= ST_MUL1;
               cnt   <= '0;
            end
            ST_MUL1: begin
               cnt <= cnt + 1'b1;
               if (cnt == C_LAST_IT) state <= ST_MUL2;
            end
            ST_MUL2: begin
               cnt <= cnt + 1'b1;
               if (cnt == C_FINAL) state <= ST_OUT;
            end
            ST_OUT:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done = done_q;

   // independent cycle tally since the accepted start, used only for checking
   logic [CW:0] chk_cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          chk_cyc <= '0;
      else if (load)                       chk_cyc <= '0;
      else if (chk_cyc != (CW+1)'(LAT + 1)) chk_cyc <= chk_cyc + 1'b1;
   end

   // R3: strobe arrives a fixed count of edges after the start edge
   assert_fixed_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (chk_cyc == (CW+1)'(LAT)));
   // R6: strobe is one cycle wide
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: start while busy does not restart the sequence
   assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && start) |=> !(state == ST_MUL1 && cnt == '0));
endmodule

// File: rtl/mont_nfs_mul.sv
module mont_nfs_mul #(
   parameter int unsigned MOD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [MOD_W:0]   x_in,
   input  logic [MOD_W:0]   y_in,
   input  logic [MOD_W-1:0] n_in,
   output logic             done,
   output logic [MOD_W:0]   t_out
);
   localparam int unsigned RW = MOD_W + 3;

   if (MOD_W < 2) begin : g_bad_width
      $error("mont_nfs_mul: MOD_W must be at least 2");
   end

   logic             load, iter_en, res_en, cap;
   logic             s_bit, c_bit;
   logic [MOD_W-1:0] n_held;
   logic [RW-1:0]    sum_full;
   logic [MOD_W:0]   t_q;

   mnfs_ctrl #(.MOD_W(MOD_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .load(load), .iter_en(iter_en), .res_en(res_en), .cap(cap), .done(done)
   );

   mnfs_iter #(.MOD_W(MOD_W)) u_iter (
      .clk(clk), .rst_n(rst_n), .load(load), .iter_en(iter_en), .res_en(res_en),
      .x_in(x_in), .y_in(y_in), .n_in(n_in),
      .s_bit(s_bit), .c_bit(c_bit), .n_held(n_held)
   );

   mnfs_resolve #(.RW(RW)) u_res (
      .clk(clk), .rst_n(rst_n), .clr(load), .step(res_en),
      .s_bit(s_bit), .c_bit(c_bit), .sum_o(sum_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   t_q <= '0;
      else if (cap) t_q <= sum_full[MOD_W:0];
   end

   assign t_out = t_q;

   // R2: resolved sum never reaches above the output width
   assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cap |-> (sum_full[RW-1:MOD_W+1] == '0));
   // R2: delivered result is below twice the captured modulus
   assert_below_2n_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (t_q < {n_held, 1'b0}));
   // R6: result register moves only together with the strobe
   assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(t_q));
endmodule

// File: tb/sim_mont_nfs_mul.sv
`timescale 1ns/1ps
module sim_mont_nfs_mul;
   localparam int W   = 4;
   localparam int LAT = 3 * W + 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W:0]   x_i = '0;
   logic [W:0]   y_i = '0;
   logic [W-1:0] n_i = '0;
   logic         done;
   logic [W:0]   t_o;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   mont_nfs_mul #(.MOD_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .x_in(x_i), .y_in(y_i), .n_in(n_i),
      .done(done), .t_out(t_o)
   );

   function automatic int ref_mont(input int x, input int y, input int n);
      int t = 0;
      for (int i = 0; i < W + 2; i++) begin
         int xb = (x >> i) & 1;
         int u  = t + xb * y;
         int m  = u & 1;
         t = (u + m * n) >> 1;
      end
      return t;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one operation; pulse_busy puts a stray start mid-run with other operands
   task automatic run_op(input int x, input int y, input int n, input bit pulse_busy);
      int cyc = 0;
      bit got = 1'b0;
      int exp_t, t_seen;
      @(negedge clk);
      x_i = x[W:0]; y_i = y[W:0]; n_i = n[W-1:0]; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      x_i = x_i ^ 5'h16; y_i = y_i ^ 5'h0b; n_i = 4'hd;   // R5: inputs disturbed
      while (!got && cyc < LAT + 10) begin
         @(negedge clk);
         cyc++;
         if (pulse_busy && cyc == 3) begin
            start = 1'b1; x_i = 5'h1f; y_i = 5'h11;          // R7: ignored start
         end else start = 1'b0;
         if (done) got = 1'b1;
      end
      start = 1'b0;
      check(got && cyc == LAT, "R3 latency", cyc, LAT);
      exp_t  = ref_mont(x, y, n);
      t_seen = int'(t_o);
      check(t_seen == exp_t, "R1/R5/R7 value", t_seen, exp_t);
      check(t_seen < 2 * n, "R2 below 2N", t_seen, 2 * n);
      check(((t_seen << (W + 2)) % n) == ((x * y) % n), "R1 congruence",
            (t_seen << (W + 2)) % n, (x * y) % n);
      @(negedge clk);
      check(done == 1'b0, "R6 one-cycle done", int'(done), 0);
      @(negedge clk);
      check(int'(t_o) == exp_t, "R6 hold", int'(t_o), exp_t);
   endtask

   initial begin
      #(3_000_000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R8 reset done", int'(done), 0);
      check(t_o == '0, "R8 reset t", int'(t_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(done == 1'b0, "R8 post-reset done", int'(done), 0);
      check(t_o == '0, "R8 post-reset t", int'(t_o), 0);

      // near-exhaustive sweep: every odd modulus, every legal operand pair
      for (int n = 1; n < (1 << W); n += 2)
         for (int x = 0; x < 2 * n; x++)
            for (int y = 0; y < 2 * n; y++)
               run_op(x, y, n, ((x + y) % 5) == 0);

      // R7: start in the done cycle is ignored
      begin
         int cyc = 0;
         int keep;
         bit extra = 1'b0;
         @(negedge clk);
         x_i = 5'd13; y_i = 5'd9; n_i = 4'd11; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         while (!done && cyc < LAT + 10) begin
            @(negedge clk);
            cyc++;
         end
         keep = int'(t_o);
         check(keep == ref_mont(13, 9, 11), "R1 pre-R7 value", keep, ref_mont(13, 9, 11));
         start = 1'b1; x_i = 5'd3; y_i = 5'd7;
         @(negedge clk);
         start = 1'b0;
         for (int k = 0; k < LAT + 4; k++) begin
            @(negedge clk);
            if (done) extra = 1'b1;
         end
         check(!extra, "R7 no extra done", int'(extra), 0);
         check(int'(t_o) == keep, "R7 result unchanged", int'(t_o), keep);
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule